// File: doc/BRIEF.md
# Master and Split-Completion Arbiter with Retry and Wait Limits

This block decides which of two requesters owns a shared outbound channel: the master queue, which issues new transactions, or the split queue, which returns completions for earlier split transactions. Each side has a two-bit priority. A mode bit picks the arbitration rule, either fixed priority or alternation. A grant, once given, stays up until the owner signals that its transaction is done. The block then spends one idle cycle re-arbitrating before it issues the next grant.

While a master transaction holds the channel, the block counts the retries reported for it. Once a programmed limit is exceeded, it aborts the transaction. For either owner it also times how long the target withholds its ready indication, and it records an overrun in a sticky flag. One configuration word holds the priorities, the mode, both limits and the two flags. Writing the word updates the fields, and the flags are cleared by writing ones to them. The same word is always visible on a readback port.

Top module: `split_master_arbiter`

## Requirements
- R1: At most one of `mst_gnt` and `spl_gnt` is high in any cycle. A grant rises only in the cycle after a cycle in which the block was idle and that side was requesting.
- R2: When the mode bit (bit 20) is 0 and both sides request, the side with the numerically lower priority is granted. The master priority is in bits 17:16 and the split priority in bits 19:18, and 0 is the most urgent. On a tie the master is granted.
- R3: When the mode bit is 1 and both sides request, the side that did not receive the most recent grant is granted. After reset the most recent grant counts as the split side's.
- R4: When only one side requests, that side is granted whatever the mode and the priorities.
- R5: A grant stays high whatever the request inputs do, until a cycle with `done_in` high. In the cycle after that, both grants are low. A new grant can appear one cycle later.
- R6: With a retry limit L of 1 to 255 (bits 7:0), a master transaction survives L `retry_in` pulses. On pulse L+1, in the next cycle, `abort_out` is high for one cycle, the grant is low, and the retry-cancel flag (bit 24) reads 1. Retries during a split grant are never counted.
- R7: A retry limit of 0 never aborts, however many retries arrive.
- R8: When `retry_in` and `done_in` are high in the same cycle, the transaction completes normally. No abort is raised and the retry-cancel flag is not set.
- R9: With a ready-wait limit W of 1 to 255 (bits 15:8), the wait-timeout flag (bit 25) reads 1 after W consecutive granted cycles with `trdy_in` low. A cycle with `trdy_in` high restarts the count.
- R10: A ready-wait limit of 0 never sets the wait-timeout flag.
- R11: Writing 1 to bit 24 or bit 25 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, it reads 1 afterwards.
- R12: After reset the readback word is 0. A written value appears on `cfg_rdata` in the next cycle, with bits 21 to 23 and 26 to 31 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data, including flag clear bits |
| mst_req | input | 1 | Master queue requests the channel |
| spl_req | input | 1 | Split queue requests the channel |
| retry_in | input | 1 | The target asked the current transaction to retry |
| trdy_in | input | 1 | The target is ready in this cycle |
| done_in | input | 1 | The current transaction finishes in this cycle |
| mst_gnt | output | 1 | Channel granted to the master queue |
| spl_gnt | output | 1 | Channel granted to the split queue |
| abort_out | output | 1 | One-cycle pulse: master transaction aborted after too many retries |
| cfg_rdata | output | 32 | Readback of the configuration and flags |

## Verification
Two things can fall on the same cycle. A flag can be set by the block's own logic while software writes a 1 to clear it, and the final retry that exceeds the limit can coincide with the transaction's done strobe. The bench provokes the first by raising the write strobe with the clear bit on the very cycle of the excess retry. It then expects the retry-cancel flag to read 1 and the abort pulse to appear. It provokes the second by raising `retry_in` together with `done_in` on the retry that would otherwise abort. It then expects no abort and a clear flag. Both cases are judged at the ports, one cycle after the stimulus.

// File: rtl/split_master_arbiter_pkg.sv
// Shared constants and types for the master/split arbiter.
// Assumes an 8-bit limit field and 2-bit priorities; positions are derived.
package split_master_arbiter_pkg;
    localparam int CNT_W   = 8;
    localparam int PRIO_W  = 2;
    localparam int DATA_W  = 32;

    localparam int RLIM_LSB = 0;
    localparam int WLIM_LSB = RLIM_LSB + CNT_W;
    localparam int MPRI_LSB = WLIM_LSB + CNT_W;
    localparam int SPRI_LSB = MPRI_LSB + PRIO_W;
    localparam int MODE_BIT = SPRI_LSB + PRIO_W;
    localparam int FRTY_BIT = 24;
    localparam int FWAI_BIT = FRTY_BIT + 1;

    typedef enum logic {OWN_MST = 1'b0, OWN_SPL = 1'b1} owner_e;

    typedef struct packed {
        logic              alt_mode;
        logic [PRIO_W-1:0] spl_prio;
        logic [PRIO_W-1:0] mst_prio;
        logic [CNT_W-1:0]  wait_lim;
        logic [CNT_W-1:0]  retry_lim;
    } arb_cfg_t;
endpackage

// File: rtl/sma_cfg_regs.sv
// Configuration word with two sticky flags (write-one-to-clear).
// Assumes a set and a clear in the same cycle leave the flag set.
module sma_cfg_regs
    import split_master_arbiter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_retry,
    input  logic              set_wait,
    output arb_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);
    logic flag_retry;
    logic flag_wait;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:FWAI_BIT+1], wdata[FRTY_BIT-1:MODE_BIT+1]};

    // Field storage: loaded whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= arb_cfg_t'(wdata[MODE_BIT:0]);
        end
    end

    // Sticky flags: set by events, cleared by written ones, set dominant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_retry <= 1'b0;
            flag_wait  <= 1'b0;
        end else begin
            flag_retry <= set_retry | (flag_retry & ~(wr & wdata[FRTY_BIT]));
            flag_wait  <= set_wait  | (flag_wait  & ~(wr & wdata[FWAI_BIT]));
        end
    end

    // Readback assembly.
    always_comb begin
        rdata              = '0;
        rdata[MODE_BIT:0]  = cfg;
        rdata[FRTY_BIT]    = flag_retry;
        rdata[FWAI_BIT]    = flag_wait;
    end
endmodule

// File: rtl/sma_pick.sv
// Combinational choice between master and split requests.
// Assumes last_spl tells whether the previous grant went to the split side.
module sma_pick
    import split_master_arbiter_pkg::*;
(
    input  logic              mst_req,
    input  logic              spl_req,
    input  logic              alt_mode,
    input  logic [PRIO_W-1:0] mst_prio,
    input  logic [PRIO_W-1:0] spl_prio,
    input  logic              last_spl,
    output logic              pick_mst,
    output logic              pick_spl
);
    logic spl_wins_tie_break;

    // Decide who wins when both request.
    always_comb begin
        if (alt_mode) spl_wins_tie_break = ~last_spl;
        else          spl_wins_tie_break = (spl_prio < mst_prio);
    end

    // Final one-hot pick.
    always_comb begin
        pick_spl = spl_req & (~mst_req | spl_wins_tie_break);
        pick_mst = mst_req & ~pick_spl;
    end
endmodule

// File: rtl/sma_limit_cnt.sv
// Event counter compared with a programmable limit; limit 0 disables it.
// EXCEED=1 fires on the event after LIMIT events; EXCEED=0 fires on the LIMIT-th.
module sma_limit_cnt #(
    parameter int W      = 8,
    parameter bit EXCEED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Saturating count, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (clear)               cnt <= '0;
        else if (step && cnt != '1)   cnt <= cnt + 1'b1;
    end

    // Variant chosen by parameter.
    generate
        if (EXCEED) begin : g_exceed
            assign hit = step & ~clear & (limit != '0) & (cnt == limit);
        end else begin : g_reach
            assign hit = step & ~clear & (limit != '0) & (cnt == limit - 1'b1);
        end
    endgenerate
endmodule

// File: rtl/split_master_arbiter.sv
// Top: grants the channel to master or split queue, holds it until done,
// aborts master transactions that exceed the retry limit and flags long
// ready waits. Assumes done/retry/trdy only matter while a grant is up.
module split_master_arbiter
    import split_master_arbiter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              mst_req,
    input  logic              spl_req,
    input  logic              retry_in,
    input  logic              trdy_in,
    input  logic              done_in,
    output logic              mst_gnt,
    output logic              spl_gnt,
    output logic              abort_out,
    output logic [DATA_W-1:0] cfg_rdata
);
    arb_cfg_t cfg;
    logic     busy;
    owner_e   owner;
    logic     last_spl;
    logic     abort_q;
    logic     pick_mst;
    logic     pick_spl;
    logic     start;
    logic     retry_hit;
    logic     wait_hit;

    assign start = ~busy & (pick_mst | pick_spl);

    sma_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .set_retry(retry_hit), .set_wait(wait_hit),
        .cfg(cfg), .rdata(cfg_rdata)
    );

    sma_pick u_pick (
        .mst_req(mst_req), .spl_req(spl_req), .alt_mode(cfg.alt_mode),
        .mst_prio(cfg.mst_prio), .spl_prio(cfg.spl_prio), .last_spl(last_spl),
        .pick_mst(pick_mst), .pick_spl(pick_spl)
    );

    sma_limit_cnt #(.W(CNT_W), .EXCEED(1'b1)) u_retry (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .step(busy & (owner == OWN_MST) & retry_in & ~done_in),
        .limit(cfg.retry_lim), .hit(retry_hit)
    );

    sma_limit_cnt #(.W(CNT_W), .EXCEED(1'b0)) u_wait (
        .clk(clk), .rst_n(rst_n), .clear(start | (busy & trdy_in)),
        .step(busy & ~trdy_in),
        .limit(cfg.wait_lim), .hit(wait_hit)
    );

    // Ownership: take on a pick, release on done or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            owner    <= OWN_MST;
            last_spl <= 1'b1;
        end else if (start) begin
            busy     <= 1'b1;
            owner    <= pick_spl ? OWN_SPL : OWN_MST;
            last_spl <= pick_spl;
        end else if (busy && (done_in || retry_hit)) begin
            busy     <= 1'b0;
        end
    end

    // Abort pulse, one cycle after the excess retry.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= retry_hit;
    end

    assign mst_gnt   = busy & (owner == OWN_MST);
    assign spl_gnt   = busy & (owner == OWN_SPL);
    assign abort_out = abort_q;
endmodule

// File: rtl/split_master_arbiter_chk.sv
// Port-level properties of the arbiter, bound to every instance.
module split_master_arbiter_chk
    import split_master_arbiter_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              retry_in,
    input logic              done_in,
    input logic              mst_gnt,
    input logic              spl_gnt,
    input logic              abort_out,
    input logic [DATA_W-1:0] cfg_rdata
);
    a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mst_gnt, spl_gnt}));

    a_r5_hold_mst: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_gnt && !done_in && !retry_in) |=> mst_gnt);

    a_r5_hold_spl: assert property (@(posedge clk) disable iff (!rst_n)
        (spl_gnt && !done_in) |=> spl_gnt);

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((mst_gnt || spl_gnt) && done_in) |=> (!mst_gnt && !spl_gnt));

    a_r6_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_out) |-> ($past(mst_gnt && retry_in && !done_in) && !mst_gnt && !spl_gnt));

    a_r7_zero_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_gnt && retry_in && cfg_rdata[RLIM_LSB +: CNT_W] == '0) |=> !abort_out);

    a_r11_sticky_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[FRTY_BIT] && !(cfg_wr && cfg_wdata[FRTY_BIT])) |=> cfg_rdata[FRTY_BIT]);

    a_r11_sticky_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[FWAI_BIT] && !(cfg_wr && cfg_wdata[FWAI_BIT])) |=> cfg_rdata[FWAI_BIT]);
endmodule

bind split_master_arbiter split_master_arbiter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .retry_in(retry_in), .done_in(done_in), .mst_gnt(mst_gnt),
    .spl_gnt(spl_gnt), .abort_out(abort_out), .cfg_rdata(cfg_rdata)
);

// File: tb/split_master_arbiter_test.sv
module split_master_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        mst_req = 1'b0, spl_req = 1'b0;
    logic        retry_in = 1'b0, trdy_in = 1'b0, done_in = 1'b0;
    logic        mst_gnt, spl_gnt, abort_out;
    logic [31:0] cfg_rdata;

    int nchk = 0;
    int nerr = 0;
    logic [31:0] cur;
    logic        last_spl;

    split_master_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .mst_req(mst_req), .spl_req(spl_req), .retry_in(retry_in),
        .trdy_in(trdy_in), .done_in(done_in), .mst_gnt(mst_gnt),
        .spl_gnt(spl_gnt), .abort_out(abort_out), .cfg_rdata(cfg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word(input logic rr, input int mp, input int sp,
                                         input int wl, input int rl);
        logic [31:0] w;
        w = '0;
        w[7:0] = rl[7:0]; w[15:8] = wl[7:0];
        w[17:16] = mp[1:0]; w[19:18] = sp[1:0]; w[20] = rr;
        return w;
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [31:0] w);
        cfg_wdata = w; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic setcfg(input logic [31:0] w);
        cur = w; wcfg(w);
    endtask

    task automatic clear_flags();
        wcfg(cur | 32'h0300_0000);
    endtask

    task automatic grant(input logic m, input logic s);
        mst_req = m; spl_req = s; tick(); mst_req = 1'b0; spl_req = 1'b0;
    endtask

    task automatic finish_txn(input string req);
        done_in = 1'b1; tick(); done_in = 1'b0;
        chk(req, {spl_gnt, mst_gnt}, 0);
        tick();
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        last_spl = 1'b1;
        // R12 reset state
        chk("R12 reset rdata", int'(cfg_rdata), 0);
        chk("R1 reset grants", {spl_gnt, mst_gnt}, 0);
        chk("R6 reset abort", abort_out, 0);
        // R12 readback layout, unused bits read 0
        wcfg(32'hFFE0_0000 | word(1, 2, 3, 8'h5A, 8'hA5));
        chk("R12 readback", int'(cfg_rdata), int'(word(1, 2, 3, 8'h5A, 8'hA5)));
        setcfg(word(0, 0, 0, 0, 0));

        // R2 exhaustive fixed-priority sweep with both requesting
        for (int mp = 0; mp < 4; mp++) begin
            for (int sp = 0; sp < 4; sp++) begin
                setcfg(word(0, mp, sp, 0, 0));
                grant(1, 1);
                chk($sformatf("R2 fixed mp=%0d sp=%0d", mp, sp),
                    {spl_gnt, mst_gnt}, (sp < mp) ? 2 : 1);
                last_spl = (sp < mp);
                finish_txn("R5 release after done");
            end
        end

        // R4 single requester wins in either mode against any priority
        for (int rr = 0; rr < 2; rr++) begin
            setcfg(word(rr[0], 3, 0, 0, 0));
            grant(1, 0);
            chk("R4 master alone", {spl_gnt, mst_gnt}, 1);
            finish_txn("R5 release");
            setcfg(word(rr[0], 0, 3, 0, 0));
            grant(0, 1);
            chk("R4 split alone", {spl_gnt, mst_gnt}, 2);
            finish_txn("R5 release");
        end
        last_spl = 1'b1;

        // R3 alternation with both requesting
        setcfg(word(1, 0, 3, 0, 0));
        for (int i = 0; i < 6; i++) begin
            grant(1, 1);
            chk($sformatf("R3 alternate step %0d", i), {spl_gnt, mst_gnt}, last_spl ? 1 : 2);
            last_spl = ~last_spl;
            finish_txn("R5 release");
        end

        // R5 hold regardless of request, gap cycle, then re-arbitration
        setcfg(word(0, 0, 0, 0, 0));
        grant(1, 0);
        spl_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 grant held", {spl_gnt, mst_gnt}, 1);
        end
        done_in = 1'b1; tick(); done_in = 1'b0;
        chk("R5 gap cycle", {spl_gnt, mst_gnt}, 0);
        tick(); spl_req = 1'b0;
        chk("R5 next grant", {spl_gnt, mst_gnt}, 2);
        finish_txn("R5 release");

        // R6 retry limit sweep
        for (int lim = 1; lim <= 4; lim++) begin
            setcfg(word(0, 0, 0, 0, lim));
            grant(1, 0);
            for (int i = 0; i < lim; i++) begin
                retry_in = 1'b1; tick();
                chk($sformatf("R6 tolerated retry L=%0d", lim), {abort_out, mst_gnt}, 1);
            end
            retry_in = 1'b1; tick(); retry_in = 1'b0;
            chk($sformatf("R6 abort L=%0d", lim), {abort_out, spl_gnt, mst_gnt}, 4);
            chk("R6 retry flag", cfg_rdata[24], 1);
            tick();
            chk("R6 abort one cycle", abort_out, 0);
            clear_flags();
            chk("R11 flag cleared", cfg_rdata[24], 0);
        end

        // R6 retries during a split grant not counted
        setcfg(word(0, 0, 0, 0, 1));
        grant(0, 1);
        for (int i = 0; i < 3; i++) begin
            retry_in = 1'b1; tick();
            chk("R6 split retry ignored", {abort_out, spl_gnt}, 1);
        end
        retry_in = 1'b0;
        finish_txn("R5 release");
        chk("R6 split no flag", cfg_rdata[24], 0);

        // R7 limit 0 never aborts
        setcfg(word(0, 0, 0, 0, 0));
        grant(1, 0);
        for (int i = 0; i < 12; i++) begin
            retry_in = 1'b1; tick();
        end
        retry_in = 1'b0;
        chk("R7 no abort", {abort_out, mst_gnt}, 1);
        chk("R7 no flag", cfg_rdata[24], 0);
        finish_txn("R5 release");

        // R8 retry coinciding with done
        setcfg(word(0, 0, 0, 0, 1));
        grant(1, 0);
        retry_in = 1'b1; tick();
        done_in = 1'b1; tick(); retry_in = 1'b0; done_in = 1'b0;
        chk("R8 no abort on done", {abort_out, spl_gnt, mst_gnt}, 0);
        chk("R8 no flag", cfg_rdata[24], 0);
        tick();

        // R11 set and clear in the same cycle: set dominates
        grant(1, 0);
        retry_in = 1'b1; tick();
        cfg_wr = 1'b1; cfg_wdata = cur | 32'h0100_0000; tick();
        cfg_wr = 1'b0; cfg_wdata = '0; retry_in = 1'b0;
        chk("R11 set beats clear flag", cfg_rdata[24], 1);
        chk("R6 abort with clear", abort_out, 1);
        tick();
        wcfg(cur);
        chk("R11 zero write keeps flag", cfg_rdata[24], 1);
        clear_flags();
        chk("R11 one write clears", cfg_rdata[24], 0);

        // R9 ready-wait limit sweep
        for (int lim = 1; lim <= 5; lim++) begin
            setcfg(word(0, 0, 0, lim, 0));
            grant(1, 0);
            for (int i = 0; i < lim - 1; i++) tick();
            chk($sformatf("R9 below limit W=%0d", lim), cfg_rdata[25], 0);
            tick();
            chk($sformatf("R9 at limit W=%0d", lim), cfg_rdata[25], 1);
            finish_txn("R5 release");
            clear_flags();
            chk("R11 wait flag cleared", cfg_rdata[25], 0);
        end

        // R9 ready restarts the count (split owner)
        setcfg(word(0, 0, 0, 3, 0));
        grant(0, 1);
        tick(); tick();
        trdy_in = 1'b1; tick(); trdy_in = 1'b0;
        tick(); tick();
        chk("R9 restart no flag", cfg_rdata[25], 0);
        tick();
        chk("R9 restart flag", cfg_rdata[25], 1);
        finish_txn("R5 release");
        clear_flags();

        // R10 limit 0 disables the wait timer
        setcfg(word(0, 0, 0, 0, 0));
        grant(1, 0);
        for (int i = 0; i < 30; i++) tick();
        chk("R10 disabled", cfg_rdata[25], 0);
        finish_txn("R5 release");

        report();
    end
endmodule